// File: doc/BRIEF.md
# Snooping Victim Cache Bus Agent

This block is a second cache-holding agent on a shared snooping bus where one processor is the only other requester. It keeps a direct-mapped store of the modified lines that the processor writes back to memory. It fills that store only by watching those write-backs go past. When the processor later asks for one of those lines, the agent claims it with a modified-line snoop hit. It then hands the 32-byte line over directly as four 64-bit beats, so the memory target is updated from the same transfer.

An external bus tracker classifies each transaction and marks its phases. It gives the agent a request strobe with the address and kind, a snoop-phase strobe, the bus target-ready, and the bus data-ready signal with the data for write-backs. The agent returns the active-low modified-hit signal, its own data-ready and data-busy, and the data bus with an output enable. The tracker presents one transaction to the agent at a time. Its snoop strobe comes exactly two cycles after the request strobe.

Top module: `vcache_agent`

## Requirements
- R1: After reset, hitm_n, drdy_n and dbsy_n are 1, data_oe is 0, and every line is invalid.
- R2: A read (req_kind 2) to a line not held leaves hitm_n at 1 in the snoop cycle and drives no data.
- R3: A write-back (req_kind 1) stores the four beats that come with bus_drdy_n low, in order, with beat 0 at quadword offset 0; idle cycles between beats are skipped. A later read of that line pulls hitm_n low only in the cycle where snp_ph is 1.
- R4: After a hit, no data is driven until target-ready (trdy_n low) has been sampled. The first beat appears in the cycle after the first clock edge at which trdy_n is low, and trdy_n that is already low during the snoop cycle counts from the edge after it.
- R5: A supply is four consecutive cycles with drdy_n low and data_oe high, carrying beats 0,1,2,3. dbsy_n is low on beats 0 to 2 and high on beat 3, and everything is released in the following cycle.
- R6: A read hit leaves the line held, so a second read of it hits again with the same data.
- R7: A read-for-ownership (req_kind 3) that hits is answered like a read and also drops the line, so a later read misses.
- R8: An invalidate (req_kind 4) that hits drops the line, with hitm_n staying 1 and no data driven.
- R9: A write-back to an index that already holds a line replaces it. A read of the old address misses, and a read of the new address returns the new data.
- R10: The index is req_addr[IDX_W+4:5] and the tag is the bits above it, so lines at different indexes are held together.
- R11: Any other kind (req_kind 0, 5 to 7) is ignored: no snoop hit, and data beats that follow it are not stored.
- R12: req_addr[4:0] takes no part in lookup or fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request-phase strobe from the tracker |
| req_addr | input | ADDR_W | Byte address of the transaction |
| req_kind | input | 3 | Kind: 0 other, 1 write-back, 2 read, 3 read-for-ownership, 4 invalidate |
| snp_ph | input | 1 | Snoop-phase strobe of the current transaction |
| trdy_n | input | 1 | Bus target-ready, active low |
| bus_drdy_n | input | 1 | Bus data-ready as sampled, active low, qualifies write-back beats |
| bus_data_in | input | 64 | Data bus as sampled |
| hitm_n | output | 1 | Modified-line snoop hit, active low |
| drdy_n | output | 1 | Agent data-ready, active low |
| dbsy_n | output | 1 | Agent data-busy, active low |
| data_oe | output | 1 | Agent drives the data bus |
| data_out | output | 64 | Data driven during a supply |

## Verification
Two things fall in the same cycle on a read-for-ownership hit: the snoop answer and the dropping of the line. The bench provokes this with a read-for-ownership to a held line. It judges the result by the low hitm_n in that cycle, the full four-beat supply that follows, and a miss on the next read of the address. The second overlap is target-ready already asserted in the snoop cycle, alongside the snoop answer. The bench holds trdy_n low together with snp_ph and expects the first beat exactly two cycles later, never in the cycle after the snoop.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  localparam int QW_BITS = 64;
  localparam int BEATS   = 4;
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int OFS_W   = 5;

  typedef enum logic [2:0] {
    TK_OTHER = 3'd0,
    TK_WBACK = 3'd1,
    TK_READ  = 3'd2,
    TK_RFO   = 3'd3,
    TK_INVAL = 3'd4
  } tkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_LOOK, ST_SNP, ST_WAIT, ST_SEND
  } ag_state_e;
endpackage

// File: rtl/vc_dpram.sv
module vc_dpram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vc_valid.sv
module vc_valid #(
  parameter int LINES = 32,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid
);
  logic [LINES-1:0] v_q;
  logic [LINES-1:0] v_d;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_comb begin
      v_d[g] = v_q[g];
      if (set_en && set_idx == IW'(g)) v_d[g] = 1'b1;
      if (clr_en && clr_idx == IW'(g)) v_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[g] <= 1'b0;
      else        v_q[g] <= v_d[g];
    end
  end

  assign rd_valid = v_q[rd_idx];

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R8
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> v_q[$past(set_idx)]); // R3
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vcache_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int TAG_W = 22,
  localparam int DA_W = IDX_W + BEAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [2:0]       req_kind,
  input  logic             snp_ph,
  input  logic             trdy_n,
  input  logic             bus_drdy_n,
  input  logic [TAG_W-1:0] tag_rdata,
  input  logic             line_valid,
  output logic             tag_rd_en,
  output logic [IDX_W-1:0] cur_idx,
  output logic [TAG_W-1:0] cur_tag,
  output logic             fill_line,
  output logic             drop_line,
  output logic             dat_we,
  output logic [DA_W-1:0]  dat_waddr,
  output logic [DA_W-1:0]  dat_raddr,
  output logic             hitm_n,
  output logic             drdy_n,
  output logic             dbsy_n,
  output logic             data_oe
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  ag_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [2:0]        kind_q, kind_d;
  logic              hit_q, hit_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              snoop_hit;
  logic              supplies;

  assign supplies = (kind_q == TK_READ) || (kind_q == TK_RFO);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    tag_d  = tag_q;
    kind_d = kind_q;
    hit_d  = hit_q;
    beat_d = beat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          idx_d  = req_idx;
          tag_d  = req_tag;
          kind_d = req_kind;
          beat_d = '0;
          if (req_kind == TK_WBACK) st_d = ST_CAP;
          else if (req_kind == TK_READ || req_kind == TK_RFO ||
                   req_kind == TK_INVAL) st_d = ST_LOOK;
        end
      end
      ST_CAP: begin
        if (!bus_drdy_n) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_d = ST_IDLE;
        end
      end
      ST_LOOK: begin
        hit_d = line_valid && (tag_rdata == tag_q);
        st_d  = ST_SNP;
      end
      ST_SNP: begin
        if (snp_ph) begin
          beat_d = '0;
          st_d   = (hit_q && supplies) ? ST_WAIT : ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (!trdy_n) st_d = ST_SEND;
      end
      ST_SEND: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      tag_q  <= '0;
      kind_q <= '0;
      hit_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      tag_q  <= tag_d;
      kind_q <= kind_d;
      hit_q  <= hit_d;
      beat_q <= beat_d;
    end
  end

  assign tag_rd_en = (st_q == ST_IDLE) && req_valid;
  assign cur_idx   = idx_q;
  assign cur_tag   = tag_q;

  assign dat_we    = (st_q == ST_CAP) && !bus_drdy_n;
  assign dat_waddr = {idx_q, beat_q};
  assign fill_line = dat_we && (beat_q == LAST_BEAT);

  assign snoop_hit = (st_q == ST_SNP) && snp_ph && hit_q;
  assign hitm_n    = !(snoop_hit && supplies);
  assign drop_line = snoop_hit && (kind_q == TK_RFO || kind_q == TK_INVAL);

  assign dat_raddr = (st_q == ST_SEND) ? {idx_q, beat_q + 1'b1} : {idx_q, {BEAT_W{1'b0}}};

  assign data_oe = (st_q == ST_SEND);
  assign drdy_n  = !(st_q == ST_SEND);
  assign dbsy_n  = !((st_q == ST_SEND) && (beat_q != LAST_BEAT));

  AST_DATA_AFTER_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(!trdy_n)); // R4
  AST_BUSY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dbsy_n |-> !drdy_n); // R5
  AST_LAST_BEAT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_n && dbsy_n) |=> (drdy_n && !data_oe)); // R5
  AST_HITM_ONLY_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> snp_ph); // R3
  AST_HITM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |=> hitm_n); // R3
  AST_NO_DRIVE_ON_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_line && hitm_n) |=> !data_oe); // R8
endmodule

// File: rtl/vcache_agent.sv
module vcache_agent
  import vcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W,
  localparam int DA_W  = IDX_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_kind,
  input  logic              snp_ph,
  input  logic              trdy_n,
  input  logic              bus_drdy_n,
  input  logic [63:0]       bus_data_in,
  output logic              hitm_n,
  output logic              drdy_n,
  output logic              dbsy_n,
  output logic              data_oe,
  output logic [63:0]       data_out
);
  logic [IDX_W-1:0] req_idx, cur_idx;
  logic [TAG_W-1:0] req_tag, cur_tag, tag_rdata;
  logic             tag_rd_en, line_valid, fill_line, drop_line, dat_we;
  logic [DA_W-1:0]  dat_waddr, dat_raddr;
  logic [QW_BITS-1:0] dat_rdata;

  assign req_idx = req_addr[OFS_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  vc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_tag(req_tag), .req_kind(req_kind), .snp_ph(snp_ph), .trdy_n(trdy_n),
    .bus_drdy_n(bus_drdy_n), .tag_rdata(tag_rdata), .line_valid(line_valid),
    .tag_rd_en(tag_rd_en), .cur_idx(cur_idx), .cur_tag(cur_tag),
    .fill_line(fill_line), .drop_line(drop_line), .dat_we(dat_we),
    .dat_waddr(dat_waddr), .dat_raddr(dat_raddr), .hitm_n(hitm_n),
    .drdy_n(drdy_n), .dbsy_n(dbsy_n), .data_oe(data_oe)
  );

  vc_dpram #(.WIDTH(TAG_W), .DEPTH(LINES)) u_tags (
    .clk(clk), .we(fill_line), .waddr(cur_idx), .wdata(cur_tag),
    .re(tag_rd_en), .raddr(req_idx), .rdata(tag_rdata)
  );

  vc_dpram #(.WIDTH(QW_BITS), .DEPTH(LINES * BEATS)) u_data (
    .clk(clk), .we(dat_we), .waddr(dat_waddr), .wdata(bus_data_in),
    .re(1'b1), .raddr(dat_raddr), .rdata(dat_rdata)
  );

  vc_valid #(.LINES(LINES)) u_valid (
    .clk(clk), .rst_n(rst_n), .set_en(fill_line), .set_idx(cur_idx),
    .clr_en(drop_line), .clr_idx(cur_idx), .rd_idx(cur_idx),
    .rd_valid(line_valid)
  );

  assign data_out = data_oe ? dat_rdata : '0;
endmodule

// File: tb/sim_vcache_agent.sv
module sim_vcache_agent;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_kind;
  logic        snp_ph, trdy_n, bus_drdy_n;
  logic [63:0] bus_data_in;
  logic        hitm_n, drdy_n, dbsy_n, data_oe;
  logic [63:0] data_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  vcache_agent u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .snp_ph(snp_ph), .trdy_n(trdy_n),
    .bus_drdy_n(bus_drdy_n), .bus_data_in(bus_data_in), .hitm_n(hitm_n),
    .drdy_n(drdy_n), .dbsy_n(dbsy_n), .data_oe(data_oe), .data_out(data_out)
  );

  function automatic logic [63:0] pat(input logic [31:0] a, input logic [7:0] s, input int b);
    return {a, s, 22'd0, 2'(b)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wback(input logic [31:0] a, input logic [7:0] s, input bit gap, input logic [2:0] kind);
    req_valid = 1'b1; req_addr = a; req_kind = kind;
    tick();
    req_valid = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (gap && b == 2) begin
        bus_drdy_n = 1'b1;
        tick();
      end
      bus_drdy_n = 1'b0; bus_data_in = pat(a, s, b);
      tick();
    end
    bus_drdy_n = 1'b1; bus_data_in = '0;
  endtask

  // snoop a transaction; when exp_hit, wait tdly cycles for target-ready and check the supply
  task automatic snoop(input logic [31:0] a, input logic [2:0] kind, input bit exp_hit,
                       input logic [31:0] da, input logic [7:0] s, input int tdly,
                       input bit early, input string rq);
    req_valid = 1'b1; req_addr = a; req_kind = kind;
    tick();
    req_valid = 1'b0;
    tick();
    snp_ph = 1'b1;
    if (early) trdy_n = 1'b0;
    @(negedge clk);
    chk(hitm_n == !exp_hit, {rq, " hitm_n in snoop"}, 64'(hitm_n), 64'(!exp_hit));
    chk(data_oe == 1'b0 && drdy_n, {rq, " no drive in snoop"}, 64'(data_oe), 64'd0);
    tick();
    snp_ph = 1'b0;
    @(negedge clk);
    chk(hitm_n == 1'b1, {rq, " hitm_n after snoop"}, 64'(hitm_n), 64'd1);
    chk(data_oe == 1'b0, {rq, " R4 no data in cycle after snoop"}, 64'(data_oe), 64'd0);
    if (exp_hit) begin
      if (!early) begin
        for (int w = 0; w < tdly; w++) begin
          tick();
          @(negedge clk);
          chk(data_oe == 1'b0 && drdy_n == 1'b1, {rq, " R4 wait for trdy"}, 64'(data_oe), 64'd0);
        end
        tick();
        trdy_n = 1'b0;
      end
      tick();
      trdy_n = 1'b1;
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        chk(drdy_n == 1'b0 && data_oe == 1'b1, {rq, " R5 drdy beat"}, 64'(drdy_n), 64'd0);
        chk(dbsy_n == (b == 3), {rq, " R5 dbsy beat"}, 64'(dbsy_n), 64'(b == 3));
        chk(data_out == pat(da, s, b), {rq, " R3 beat data"}, data_out, pat(da, s, b));
        tick();
      end
      @(negedge clk);
      chk(drdy_n && dbsy_n && !data_oe, {rq, " R5 release"}, {61'd0, drdy_n, dbsy_n, data_oe}, 64'd6);
      tick();
    end else begin
      trdy_n = 1'b0;
      for (int w = 0; w < 3; w++) begin
        tick();
        @(negedge clk);
        chk(data_oe == 1'b0 && drdy_n && dbsy_n, {rq, " no supply"}, 64'(data_oe), 64'd0);
      end
      trdy_n = 1'b1;
      tick();
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(hitm_n && drdy_n && dbsy_n && !data_oe, "R1 reset outputs",
        {60'd0, hitm_n, drdy_n, dbsy_n, data_oe}, 64'he);
  endtask

  task automatic t_miss_empty();
    snoop(32'h0000_0100, 3'd2, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R2 empty miss");
  endtask

  task automatic t_fill_read();
    wback(32'h0000_1040, 8'h11, 1'b1, 3'd1);
    snoop(32'h0000_1040, 3'd2, 1'b1, 32'h0000_1040, 8'h11, 3, 1'b0, "R3 R4 fill then read");
  endtask

  task automatic t_read_keeps();
    snoop(32'h0000_1040, 3'd2, 1'b1, 32'h0000_1040, 8'h11, 0, 1'b1, "R6 R4 reread early trdy");
  endtask

  task automatic t_other();
    wback(32'h0000_1040, 8'h22, 1'b0, 3'd0);
    snoop(32'h0000_1040, 3'd0, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R11 other kind");
    wback(32'h0000_1040, 8'h33, 1'b0, 3'd6);
    snoop(32'h0000_1040, 3'd2, 1'b1, 32'h0000_1040, 8'h11, 1, 1'b0, "R11 data untouched");
  endtask

  task automatic t_offset();
    snoop(32'h0000_105F, 3'd2, 1'b1, 32'h0000_1040, 8'h11, 0, 1'b0, "R12 offset ignored");
  endtask

  task automatic t_rfo();
    snoop(32'h0000_1040, 3'd3, 1'b1, 32'h0000_1040, 8'h11, 2, 1'b0, "R7 rfo supply");
    snoop(32'h0000_1040, 3'd2, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R7 line dropped");
  endtask

  task automatic t_inval();
    wback(32'h0000_3000, 8'h44, 1'b0, 3'd1);
    snoop(32'h0000_3000, 3'd4, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R8 inval hit no hitm");
    snoop(32'h0000_3000, 3'd2, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R8 line dropped");
  endtask

  task automatic t_overwrite();
    wback(32'h0000_2060, 8'h55, 1'b0, 3'd1);
    wback(32'h0000_4060, 8'h66, 1'b1, 3'd1);
    snoop(32'h0000_2060, 3'd2, 1'b0, 32'h0, 8'h0, 0, 1'b0, "R9 old tag miss");
    snoop(32'h0000_4060, 3'd2, 1'b1, 32'h0000_4060, 8'h66, 1, 1'b0, "R9 new line");
  endtask

  task automatic t_coexist();
    wback(32'h0000_0080, 8'h77, 1'b0, 3'd1);
    wback(32'h0000_00A0, 8'h88, 1'b0, 3'd1);
    snoop(32'h0000_0080, 3'd2, 1'b1, 32'h0000_0080, 8'h77, 0, 1'b0, "R10 index 4");
    snoop(32'h0000_00A0, 3'd2, 1'b1, 32'h0000_00A0, 8'h88, 0, 1'b0, "R10 index 5");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0;
    snp_ph = 1'b0; trdy_n = 1'b1; bus_drdy_n = 1'b1; bus_data_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_miss_empty();
    t_fill_read();
    t_read_keeps();
    t_other();
    t_offset();
    t_rfo();
    t_inval();
    t_overwrite();
    t_coexist();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule